// File: doc/BRIEF.md
# Converter Host Bus Command Interface

This block is the parallel host-side front end of a sampling analog-to-digital converter. A processor reaches it through an active-low chip select and active-low read and write strobes. It sees the block's state on an active-low ready output and a sync output that marks the conversion phase. A write loads an eight-bit configuration word. That word carries a command, a bus-width select, a sync-mode bit and a two-bit acquisition-time select. The block then runs the command: it starts a full calibration or an offset-only calibration, clears itself back to defaults, arms conversions, or parks in a low-activity standby.

Conversions are started by reads, not by writes. With conversions armed, a read returns the previous result. The rising edge of the read that finishes a result transfer starts a new acquisition period: the second of two byte reads in narrow mode, or the single read in wide mode. A conversion follows the acquisition period. The calibration engine and the analog converter sit outside this block. Each is driven through a start pulse and answers with a one-cycle done pulse; the converter's done pulse carries its 13-bit result.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After the reset input is released the block is in standby. readyN is high and syncOut is low, and reads do not start a conversion.
- R2: A Standby command (code 4'h4) enters standby with readyN high. A Start (4'h3), Full-Cal (4'h1), Auto-Zero (4'h2) or Reset (4'h0) command leaves standby and drives readyN low once any work that command starts has finished.
- R3: The write edge of a Full-Cal or Auto-Zero command drives readyN high and gives one calStart pulse, with calFull high for Full-Cal and low for Auto-Zero. readyN returns low on the cycle after calDone.
- R4: The configuration word is laid out as follows: bits 7:4 hold the command, bit 3 is the width select (0 = 8-bit, 1 = 13-bit), bit 2 is the sync-mode bit, and bits 1:0 are the acquisition select. Any command code other than 4'h0 to 4'h4 is stored but starts no action, and reads do not trigger while it is loaded.
- R5: Acquisition select values 0, 1, 2 and 3 give acquisition periods of 9, 15, 47 and 79 clock cycles, measured from the first cycle readyN is high after a trigger to the cycle syncOut rises.
- R6: A trigger drives readyN high at once. syncOut rises when the acquisition period ends, together with one convStart pulse. Both fall on the cycle after convDone.
- R7: In 8-bit mode with Start loaded, the first read returns the result's low byte on busData[7:0] and the second read returns result bits 12:8 on busData[4:0]. All other busData bits are zero. Only the rising edge of the second read triggers a conversion.
- R8: In 13-bit mode with Start loaded, one read returns the whole result on busData[12:0], and its rising edge triggers a conversion.
- R9: Read and write strobes have no effect while csN is high.
- R10: Every accepted write resets the 8-bit byte pointer to the low byte.
- R11: A Reset command clears the configuration word to zero and aborts an acquisition or conversion in progress without issuing convStart. readyN is then low, and later reads do not trigger until Start is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| dataIn | input | 8 | Configuration word from the host |
| busData | output | 13 | Result data returned to the host |
| readyN | output | 1 | Active-low ready to accept a command |
| syncOut | output | 1 | High while a conversion runs |
| calStart | output | 1 | One-cycle calibration request |
| calFull | output | 1 | Calibration kind: 1 full, 0 offset only |
| calDone | input | 1 | One-cycle calibration completion |
| convStart | output | 1 | One-cycle conversion request |
| convDone | input | 1 | One-cycle conversion completion |
| convResult | input | 13 | Converter result, valid with convDone |

## Verification
The assertions assume that calDone and convDone are single-cycle pulses that arrive only while the matching phase is active. They also assume that the host does not complete a write on the same cycle that a done pulse arrives. The bench models the converter and the calibration engine as answering a fixed number of cycles after each start pulse. It holds dataIn steady across the whole write strobe. It waits for readyN low before each transfer, except where a test deliberately aborts an acquisition with a Reset command. The strobe widths are kept long enough for the two-stage synchroniser to see every pulse.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

  typedef enum logic [3:0] {
    CMD_RESET    = 4'h0,
    CMD_FULLCAL  = 4'h1,
    CMD_AUTOZERO = 4'h2,
    CMD_START    = 4'h3,
    CMD_STANDBY  = 4'h4
  } cmdCode_t;

  typedef struct packed {
    logic [3:0] cmd;
    logic       wide;
    logic       syncMode;
    logic [1:0] acqSel;
  } cfgWord_t;

  typedef enum logic [2:0] {
    ST_STANDBY,
    ST_IDLE,
    ST_CAL,
    ST_ACQ,
    ST_CONV
  } ifState_t;

  typedef struct packed {
    logic loadResult;
    logic selHigh;
    logic wideMode;
  } dpCtl_t;

endpackage

// File: rtl/adc_bus_datapath.sv
module adc_bus_datapath
  import adc_bus_pkg::*;
#(
  parameter int unsigned RES_W  = 13,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [RES_W-1:0] convResult,
  input  dpCtl_t           ctl,
  output logic             rdEdge,
  output logic             wrEdge,
  output logic [RES_W-1:0] busData
);
  localparam int unsigned NSTR  = 2;
  localparam int unsigned DEPTH = SYNC_STAGES + 1;
  localparam int unsigned HI_W  = RES_W - BYTE_W;

  logic [NSTR-1:0] strobeAct;
  logic [NSTR-1:0] strobeEnd;
  logic [RES_W-1:0] resultReg;

  assign strobeAct[0] = ~csN & ~rdN;
  assign strobeAct[1] = ~csN & ~wrN;

  for (genvar g = 0; g < NSTR; g++) begin : g_strobe
    logic [DEPTH-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[DEPTH-2:0], strobeAct[g]};
    end
    // release of an active strobe is the detected edge
    assign strobeEnd[g] = pipe[DEPTH-1] & ~pipe[DEPTH-2];
  end

  assign rdEdge = strobeEnd[0];
  assign wrEdge = strobeEnd[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               resultReg <= '0;
    else if (ctl.loadResult) resultReg <= convResult;
  end

  always_comb begin
    if (ctl.wideMode)     busData = resultReg;
    else if (ctl.selHigh) busData = {{BYTE_W{1'b0}}, resultReg[RES_W-1:BYTE_W]};
    else                  busData = {{HI_W{1'b0}}, resultReg[BYTE_W-1:0]};
  end

endmodule

// File: rtl/adc_bus_ctrl_fsm.sv
module adc_bus_ctrl_fsm
  import adc_bus_pkg::*;
#(
  parameter int unsigned ACQ_T0 = 9,
  parameter int unsigned ACQ_T1 = 15,
  parameter int unsigned ACQ_T2 = 47,
  parameter int unsigned ACQ_T3 = 79
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEdge,
  input  logic       wrEdge,
  input  logic [7:0] dataIn,
  input  logic       calDone,
  input  logic       convDone,
  output dpCtl_t     ctl,
  output logic       readyN,
  output logic       syncOut,
  output logic       calStart,
  output logic       calFull,
  output logic       convStart
);
  localparam int unsigned ACQ_MAX01 = (ACQ_T0 > ACQ_T1) ? ACQ_T0 : ACQ_T1;
  localparam int unsigned ACQ_MAX23 = (ACQ_T2 > ACQ_T3) ? ACQ_T2 : ACQ_T3;
  localparam int unsigned ACQ_MAX   = (ACQ_MAX01 > ACQ_MAX23) ? ACQ_MAX01 : ACQ_MAX23;
  localparam int unsigned CNT_W     = $clog2(ACQ_MAX + 1);

  ifState_t   state;
  cfgWord_t   cfg;
  cfgWord_t   wrWord;
  logic       bytePtr;
  logic [CNT_W-1:0] acqCnt;
  logic [CNT_W-1:0] acqLoad;
  logic       lastRead;

  assign wrWord = cfgWord_t'(dataIn);

  always_comb begin
    unique case (cfg.acqSel)
      2'd0:    acqLoad = CNT_W'(ACQ_T0 - 1);
      2'd1:    acqLoad = CNT_W'(ACQ_T1 - 1);
      2'd2:    acqLoad = CNT_W'(ACQ_T2 - 1);
      default: acqLoad = CNT_W'(ACQ_T3 - 1);
    endcase
  end

  assign lastRead = cfg.wide | bytePtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_STANDBY;
      cfg       <= '0;
      bytePtr   <= 1'b0;
      acqCnt    <= '0;
      calStart  <= 1'b0;
      calFull   <= 1'b0;
      convStart <= 1'b0;
    end else begin
      calStart  <= 1'b0;
      convStart <= 1'b0;
      if (wrEdge) begin
        cfg     <= wrWord;
        bytePtr <= 1'b0;
        unique case (wrWord.cmd)
          CMD_RESET: begin
            cfg   <= '0;
            state <= ST_IDLE;
          end
          CMD_FULLCAL, CMD_AUTOZERO: begin
            state    <= ST_CAL;
            calStart <= 1'b1;
            calFull  <= (wrWord.cmd == CMD_FULLCAL);
          end
          CMD_START:   if (state == ST_STANDBY) state <= ST_IDLE;
          CMD_STANDBY: state <= ST_STANDBY;
          default: ;
        endcase
      end else begin
        unique case (state)
          ST_IDLE: if (rdEdge && cfg.cmd == CMD_START) begin
            if (lastRead) begin
              bytePtr <= 1'b0;
              acqCnt  <= acqLoad;
              state   <= ST_ACQ;
            end else begin
              bytePtr <= 1'b1;
            end
          end
          ST_ACQ: begin
            if (acqCnt == '0) begin
              state     <= ST_CONV;
              convStart <= 1'b1;
            end else begin
              acqCnt <= acqCnt - 1'b1;
            end
          end
          ST_CONV: if (convDone) state <= ST_IDLE;
          ST_CAL:  if (calDone)  state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  assign readyN  = (state != ST_IDLE);
  assign syncOut = (state == ST_CONV);

  assign ctl.loadResult = (state == ST_CONV) && convDone && !wrEdge;
  assign ctl.selHigh    = bytePtr;
  assign ctl.wideMode   = cfg.wide;

  // R6: the conversion phase is never reported as ready
  p_sync_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |-> readyN);

  // R6: the converter request coincides with the rise of sync
  p_convstart_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> syncOut);

  // R6: completion drops both sync and ready
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (syncOut && convDone && !wrEdge) |=> (!syncOut && !readyN));

  // R3: calibration request only while busy
  p_cal_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    calStart |-> readyN);

  // R3: calibration completion releases ready
  p_cal_done_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAL && calDone && !wrEdge) |=> !readyN);

  // R11: reset command clears configuration and aborts work
  p_reset_cmd_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEdge && dataIn[7:4] == 4'h0) |=> (cfg == '0 && !readyN && !syncOut));

  // R5: acquisition counter stays within the longest setting
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    acqCnt <= CNT_W'(ACQ_MAX));

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int unsigned RES_W  = 13,
  parameter int unsigned ACQ_T0 = 9,
  parameter int unsigned ACQ_T1 = 15,
  parameter int unsigned ACQ_T2 = 47,
  parameter int unsigned ACQ_T3 = 79
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [7:0]       dataIn,
  output logic [RES_W-1:0] busData,
  output logic             readyN,
  output logic             syncOut,
  output logic             calStart,
  output logic             calFull,
  input  logic             calDone,
  output logic             convStart,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult
);
  dpCtl_t ctl;
  logic   rdEdge;
  logic   wrEdge;

  adc_bus_datapath #(.RES_W(RES_W), .BYTE_W(8), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .convResult(convResult), .ctl(ctl),
    .rdEdge(rdEdge), .wrEdge(wrEdge), .busData(busData)
  );

  adc_bus_ctrl_fsm #(.ACQ_T0(ACQ_T0), .ACQ_T1(ACQ_T1),
                     .ACQ_T2(ACQ_T2), .ACQ_T3(ACQ_T3)) u_ctl (
    .clk(clk), .rstN(rstN), .rdEdge(rdEdge), .wrEdge(wrEdge),
    .dataIn(dataIn), .calDone(calDone), .convDone(convDone),
    .ctl(ctl), .readyN(readyN), .syncOut(syncOut),
    .calStart(calStart), .calFull(calFull), .convStart(convStart)
  );

endmodule

// File: tb/adc_bus_ctrl_test.sv
module adc_bus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0]  dataIn = '0;
  logic [12:0] busData;
  logic        readyN, syncOut, calStart, calFull, convStart;
  logic        calDone = 1'b0, convDone = 1'b0;
  logic [12:0] convResult = '0;

  int checks = 0, fails = 0;
  int convCount = 0, calCount = 0;
  logic lastCalFull = 1'b0;
  logic [12:0] nextRes = 13'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_ctrl uut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .dataIn(dataIn),
    .busData(busData), .readyN(readyN), .syncOut(syncOut),
    .calStart(calStart), .calFull(calFull), .calDone(calDone),
    .convStart(convStart), .convDone(convDone), .convResult(convResult)
  );

  // converter model
  initial forever begin
    @(negedge clk);
    if (convStart) begin
      convCount++;
      repeat (5) @(negedge clk);
      convResult = nextRes;
      convDone = 1'b1;
      @(negedge clk);
      convDone = 1'b0;
    end
  end

  // calibration model
  initial forever begin
    @(negedge clk);
    if (calStart) begin
      calCount++;
      lastCalFull = calFull;
      repeat (20) @(negedge clk);
      calDone = 1'b1;
      @(negedge clk);
      calDone = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfgWord(input logic [3:0] cmd, input logic wide,
                                         input logic [1:0] acq);
    return {cmd, wide, 1'b0, acq};
  endfunction

  task automatic doWrite(input logic [7:0] v, input logic sel = 1'b1);
    @(negedge clk);
    dataIn = v; csN = ~sel; wrN = 1'b0;
    repeat (3) @(negedge clk);
    wrN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic doRead(output logic [12:0] d, input logic sel = 1'b1);
    @(negedge clk);
    csN = ~sel; rdN = 1'b0;
    repeat (3) @(negedge clk);
    d = busData;
    rdN = 1'b1;
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitReady;
    for (int i = 0; i < 2000 && readyN; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [12:0] d;
    repeat (3) @(negedge clk);
    check("R1 readyN after reset", readyN, 1);
    check("R1 syncOut after reset", syncOut, 0);
    doRead(d); doRead(d);
    repeat (20) @(negedge clk);
    check("R1 no conversion in standby", convCount, 0);
  endtask

  task automatic t_standby;
    doWrite(cfgWord(4'h3, 1'b1, 2'd0));
    check("R2 start leaves standby", readyN, 0);
    doWrite(cfgWord(4'h4, 1'b1, 2'd0));
    check("R2 standby command", readyN, 1);
    doWrite(cfgWord(4'h0, 1'b0, 2'd0));
    check("R2 reset leaves standby", readyN, 0);
  endtask

  task automatic t_cal;
    int c0 = calCount;
    doWrite(cfgWord(4'h1, 1'b0, 2'd0));
    check("R3 full-cal busy", readyN, 1);
    check("R3 full-cal kind", lastCalFull, 1);
    waitReady;
    check("R3 full-cal done", readyN, 0);
    doWrite(cfgWord(4'h2, 1'b0, 2'd0));
    check("R3 auto-zero busy", readyN, 1);
    check("R3 auto-zero kind", lastCalFull, 0);
    waitReady;
    check("R3 auto-zero done", readyN, 0);
    check("R3 two calibration pulses", calCount - c0, 2);
    doWrite(cfgWord(4'h4, 1'b0, 2'd0));
    doWrite(cfgWord(4'h2, 1'b0, 2'd0));
    waitReady;
    check("R2 auto-zero leaves standby", readyN, 0);
  endtask

  task automatic t_acq;
    int exp[4] = '{9, 15, 47, 79};
    for (int a = 0; a < 4; a++) begin
      int n = 0;
      int c0;
      doWrite(cfgWord(4'h3, 1'b1, 2'(a)));
      c0 = convCount;
      @(negedge clk);
      csN = 1'b0; rdN = 1'b0;
      repeat (3) @(negedge clk);
      rdN = 1'b1;
      for (int i = 0; i < 20 && !readyN; i++) @(negedge clk);
      check("R6 trigger raises readyN", readyN, 1);
      while (!syncOut && n < 200) begin
        @(negedge clk);
        n++;
      end
      csN = 1'b1;
      check("R5 acquisition length", n, exp[a]);
      check("R6 one convStart", convCount - c0, 1);
      while (syncOut) @(negedge clk);
      check("R6 ready falls with sync", readyN, 0);
    end
  endtask

  task automatic t_byte8;
    logic [12:0] d;
    nextRes = 13'h1A5C;
    doWrite(cfgWord(4'h3, 1'b0, 2'd0));
    doRead(d); doRead(d);
    waitReady;
    doRead(d);
    check("R7 low byte", d, 13'h005C);
    check("R7 first read no trigger", readyN, 0);
    doRead(d);
    check("R7 high byte", d, 13'h001A);
    check("R7 second read triggers", readyN, 1);
    waitReady;
  endtask

  task automatic t_word13;
    logic [12:0] d;
    nextRes = 13'h0B37;
    doWrite(cfgWord(4'h3, 1'b1, 2'd0));
    doRead(d);
    waitReady;
    doRead(d);
    check("R8 whole word", d, 13'h0B37);
    check("R8 single read triggers", readyN, 1);
    waitReady;
  endtask

  task automatic t_cs;
    logic [12:0] d;
    int c0;
    doWrite(cfgWord(4'h3, 1'b0, 2'd0));
    c0 = convCount;
    doRead(d, 1'b0); doRead(d, 1'b0);
    repeat (20) @(negedge clk);
    check("R9 deselected reads ignored", convCount - c0, 0);
    doWrite(cfgWord(4'h4, 1'b0, 2'd0), 1'b0);
    check("R9 deselected write ignored", readyN, 0);
  endtask

  task automatic t_ptr;
    logic [12:0] d;
    nextRes = 13'h1F81;
    doWrite(cfgWord(4'h3, 1'b1, 2'd0));
    doRead(d);
    waitReady;
    doWrite(cfgWord(4'h3, 1'b0, 2'd0));
    doRead(d);
    check("R10 pointer advanced", d, 13'h0081);
    doWrite(cfgWord(4'h3, 1'b0, 2'd0));
    doRead(d);
    check("R10 write resets pointer", d, 13'h0081);
    check("R10 no trigger after pointer reset", readyN, 0);
  endtask

  task automatic t_other;
    logic [12:0] d;
    int c0;
    doWrite(cfgWord(4'h9, 1'b1, 2'd0));
    check("R4 unknown code no action", readyN, 0);
    c0 = convCount;
    doRead(d);
    repeat (20) @(negedge clk);
    check("R4 unknown code no trigger", convCount - c0, 0);
  endtask

  task automatic t_reset_cmd;
    logic [12:0] d;
    int c0;
    doWrite(cfgWord(4'h3, 1'b1, 2'd3));
    c0 = convCount;
    doRead(d);
    check("R11 acquisition running", readyN, 1);
    doWrite(cfgWord(4'h0, 1'b1, 2'd3));
    check("R11 reset ends acquisition", readyN, 0);
    check("R11 sync low", syncOut, 0);
    repeat (100) @(negedge clk);
    check("R11 no convStart after abort", convCount - c0, 0);
    doRead(d);
    repeat (20) @(negedge clk);
    check("R11 cleared command no trigger", convCount - c0, 0);
    check("R11 ready stays low", readyN, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_standby;
    t_cal;
    t_acq;
    t_byte8;
    t_word13;
    t_cs;
    t_ptr;
    t_other;
    t_reset_cmd;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule